// File: doc/BRIEF.md
# Scan-Chain Register Access Port for a Trace Buffer

This block sits behind a boundary-scan test access port and gives a debugger read and write access to the registers of an on-chip trace buffer. The TAP controller itself lives elsewhere: its current state arrives on `tap_state`, and this block supplies the instruction register, the data registers that the instruction selects, and the serial output. Two instructions matter. One selects a 5-bit chain-select register. The other selects a 40-bit access register, which is live only while the chain-select register holds 0, the trace buffer's chain.

Each pass through the access register carries a 32-bit data word, a 7-bit register address and a write flag. On Update-DR, a write drives the address, data and write strobe for one clock. A read issues a one-clock read strobe and latches the returned word. That word is not returned in the scan that asked for it. It comes back in the 32-bit field of the next scan's capture. A debugger reading a run of registers therefore sends one scan per address plus one trailing scan. The trailing scan should address a register that has no read side effect, so that a data port with auto-increment does not advance once too often.

Top module: `jtag_trace_access`

## Requirements
- R1: After reset the active instruction is all ones (bypass), the chain-select register is 0, the read-hold word is 0 and both strobes are low.
- R2: The 4-bit instruction register captures 4'b0001 in Capture-IR, shifts least significant bit first in Shift-IR and takes effect in Update-IR. The Test-Logic-Reset state (encoding 4'hF) restores the bypass instruction and clears the chain-select register.
- R3: Instruction 4'h2 selects the 5-bit chain-select register. Its capture loads the current chain number, and Update-DR stores the shifted value.
- R4: Instruction 4'hC selects the 40-bit access register only while the chain number is 0. With any other chain number the one-bit bypass register is selected instead.
- R5: Access-register layout, shifted in and out from bit 0: bits 31:0 hold data, bits 38:32 hold the address and bit 39 holds the write flag (1 = write, 0 = read).
- R6: A write scan raises `reg_we` for exactly one clock, in the cycle after Update-DR, with `reg_addr` and `reg_wdata` taken from the scan. `reg_re` stays low, and `reg_addr` changes only together with a strobe.
- R7: A read scan raises `reg_re` for exactly one clock, in the cycle after Update-DR, with the scanned address. `reg_we` stays low, and `reg_rdata` is latched in that cycle.
- R8: Capture-DR of the access register loads the most recently latched read word into bits 31:0 and zeros into bits 39:32. A write scan leaves that word unchanged.
- R9: Every instruction other than 4'h2 and 4'hC selects the bypass register, which captures 0 and delays `tdi` by one shift.
- R10: `tdo` is 0 outside Shift-DR and Shift-IR. In those states it carries bit 0 of the selected register.
- R11: No strobe is issued by Update-DR unless the access register is selected.
- TAP state encoding on `tap_state`: 4'hF Test-Logic-Reset, 4'hC Run-Test/Idle, 4'h7 Select-DR, 4'h6 Capture-DR, 4'h2 Shift-DR, 4'h1 Exit1-DR, 4'h3 Pause-DR, 4'h0 Exit2-DR, 4'h5 Update-DR, 4'h4 Select-IR, 4'hE Capture-IR, 4'hA Shift-IR, 4'h9 Exit1-IR, 4'hB Pause-IR, 4'h8 Exit2-IR, 4'hD Update-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_state | input | 4 | Current TAP controller state |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| reg_addr | output | 7 | Register address for the current access |
| reg_wdata | output | 32 | Write data |
| reg_we | output | 1 | One-clock write strobe |
| reg_re | output | 1 | One-clock read strobe |
| reg_rdata | input | 32 | Read data from the addressed register |

## Verification
The hardest condition to reach is the offset of one scan in the pipelined read. A read word can only be seen in the capture of a later scan. The bench therefore fills all 128 registers with distinct computed words, then reads them back in a chain of 129 scans and compares each capture with the address sent one scan earlier. It also places a write scan between two reads to show that a write leaves the held word unchanged. Gating by the chain number is reached by programming a non-zero chain before selecting the access instruction and checking that a full write command produces no strobe and only a one-bit delay.

// File: rtl/jta_pkg.sv
package jta_pkg;

  typedef enum logic [3:0] {
    TS_EXIT2_DR  = 4'h0,
    TS_EXIT1_DR  = 4'h1,
    TS_SHIFT_DR  = 4'h2,
    TS_PAUSE_DR  = 4'h3,
    TS_SEL_IR    = 4'h4,
    TS_UPD_DR    = 4'h5,
    TS_CAP_DR    = 4'h6,
    TS_SEL_DR    = 4'h7,
    TS_EXIT2_IR  = 4'h8,
    TS_EXIT1_IR  = 4'h9,
    TS_SHIFT_IR  = 4'hA,
    TS_PAUSE_IR  = 4'hB,
    TS_IDLE      = 4'hC,
    TS_UPD_IR    = 4'hD,
    TS_CAP_IR    = 4'hE,
    TS_RESET     = 4'hF
  } tap_st_e;

endpackage

// File: rtl/jta_ir.sv
module jta_ir
  import jta_pkg::*;
#(
  parameter int IR_W         = 4,
  parameter int INSTR_CHAIN  = 2,
  parameter int INSTR_ACCESS = 12
) (
  input  logic    clk,
  input  logic    rst_n,
  input  tap_st_e tap_state,
  input  logic    tdi,
  output logic    ir_tdo,
  output logic    dec_chain,
  output logic    dec_access
);

  logic [IR_W-1:0] sr_q, sr_d;
  logic [IR_W-1:0] ir_q, ir_d;

  always_comb begin
    sr_d = sr_q;
    ir_d = ir_q;
    case (tap_state)
      TS_CAP_IR:   sr_d = {{(IR_W-1){1'b0}}, 1'b1};
      TS_SHIFT_IR: sr_d = {tdi, sr_q[IR_W-1:1]};
      TS_UPD_IR:   ir_d = sr_q;
      TS_RESET:    ir_d = '1;
      default:     ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      ir_q <= '1;
    end else begin
      sr_q <= sr_d;
      ir_q <= ir_d;
    end
  end

  assign ir_tdo     = sr_q[0];
  assign dec_chain  = (ir_q == IR_W'(INSTR_CHAIN));
  assign dec_access = (ir_q == IR_W'(INSTR_ACCESS));

endmodule

// File: rtl/jta_chain_sel.sv
module jta_chain_sel
  import jta_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  tap_st_e         tap_state,
  input  logic            tdi,
  input  logic            sel,
  output logic [CH_W-1:0] chain,
  output logic            ch_tdo
);

  logic [CH_W-1:0] sr_q, sr_d;
  logic [CH_W-1:0] ch_q, ch_d;

  always_comb begin
    sr_d = sr_q;
    ch_d = ch_q;
    if (tap_state == TS_RESET) begin
      ch_d = '0;
    end else if (sel) begin
      case (tap_state)
        TS_CAP_DR:   sr_d = ch_q;
        TS_SHIFT_DR: sr_d = {tdi, sr_q[CH_W-1:1]};
        TS_UPD_DR:   ch_d = sr_q;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      ch_q <= '0;
    end else begin
      sr_q <= sr_d;
      ch_q <= ch_d;
    end
  end

  assign chain  = ch_q;
  assign ch_tdo = sr_q[0];

endmodule

// File: rtl/jta_access_dr.sv
module jta_access_dr
  import jta_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tap_st_e           tap_state,
  input  logic              tdi,
  input  logic              sel,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              acc_tdo,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re
);

  localparam int LEN   = DATA_W + ADDR_W + 1;
  localparam int WR_B  = LEN - 1;

  logic [LEN-1:0]    sr_q, sr_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              we_q, we_d;
  logic              re_q, re_d;

  always_comb begin
    sr_d    = sr_q;
    hold_d  = hold_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    we_d    = 1'b0;
    re_d    = 1'b0;
    if (re_q) begin
      hold_d = reg_rdata;
    end
    if (sel) begin
      case (tap_state)
        TS_CAP_DR:   sr_d = {{(LEN-DATA_W){1'b0}}, hold_q};
        TS_SHIFT_DR: sr_d = {tdi, sr_q[LEN-1:1]};
        TS_UPD_DR: begin
          addr_d = sr_q[DATA_W +: ADDR_W];
          if (sr_q[WR_B]) begin
            we_d    = 1'b1;
            wdata_d = sr_q[DATA_W-1:0];
          end else begin
            re_d    = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      hold_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
    end else begin
      sr_q    <= sr_d;
      hold_q  <= hold_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      we_q    <= we_d;
      re_q    <= re_d;
    end
  end

  assign acc_tdo   = sr_q[0];
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign reg_we    = we_q;
  assign reg_re    = re_q;

endmodule

// File: rtl/jtag_trace_access.sv
module jtag_trace_access
  import jta_pkg::*;
#(
  parameter int IR_W         = 4,
  parameter int INSTR_CHAIN  = 2,
  parameter int INSTR_ACCESS = 12,
  parameter int CH_W         = 5,
  parameter int TRACE_CHAIN  = 0,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        tap_state,
  input  logic              tdi,
  output logic              tdo,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata
);

  tap_st_e         st;
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            dec_chain, dec_access;
  logic            ir_tdo, ch_tdo, acc_tdo;
  logic [CH_W-1:0] chain;
  logic            sel_chain, sel_acc, sel_byp;
  logic            byp_q, byp_d;

  assign st = tap_st_e'(tap_state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  jta_ir #(
    .IR_W(IR_W), .INSTR_CHAIN(INSTR_CHAIN), .INSTR_ACCESS(INSTR_ACCESS)
  ) u_ir (
    .clk(clk), .rst_n(rst_int_n), .tap_state(st), .tdi(tdi),
    .ir_tdo(ir_tdo), .dec_chain(dec_chain), .dec_access(dec_access)
  );

  assign sel_chain = dec_chain;
  assign sel_acc   = dec_access && (chain == CH_W'(TRACE_CHAIN));
  assign sel_byp   = !sel_chain && !sel_acc;

  jta_chain_sel #(.CH_W(CH_W)) u_chain (
    .clk(clk), .rst_n(rst_int_n), .tap_state(st), .tdi(tdi),
    .sel(sel_chain), .chain(chain), .ch_tdo(ch_tdo)
  );

  jta_access_dr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_acc (
    .clk(clk), .rst_n(rst_int_n), .tap_state(st), .tdi(tdi),
    .sel(sel_acc), .reg_rdata(reg_rdata), .acc_tdo(acc_tdo),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re)
  );

  always_comb begin
    byp_d = byp_q;
    if (sel_byp) begin
      if (st == TS_CAP_DR)        byp_d = 1'b0;
      else if (st == TS_SHIFT_DR) byp_d = tdi;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) byp_q <= 1'b0;
    else            byp_q <= byp_d;
  end

  always_comb begin
    tdo = 1'b0;
    if (st == TS_SHIFT_IR) begin
      tdo = ir_tdo;
    end else if (st == TS_SHIFT_DR) begin
      if (sel_chain)    tdo = ch_tdo;
      else if (sel_acc) tdo = acc_tdo;
      else              tdo = byp_q;
    end
  end

endmodule

// File: rtl/jta_chk.sv
module jta_chk
  import jta_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        tap_state,
  input logic              tdo,
  input logic              reg_we,
  input logic              reg_re,
  input logic [ADDR_W-1:0] reg_addr
);

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);                                              // R6
  AST_RE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);                                              // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));                                             // R7
  AST_STROBE_AFTER_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || reg_re) |-> ($past(tap_state) == 4'(TS_UPD_DR)));      // R11
  AST_ADDR_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_addr) |-> (reg_we || reg_re));                       // R6
  AST_TDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_state != 4'(TS_SHIFT_DR) && tap_state != 4'(TS_SHIFT_IR))
      |-> (tdo == 1'b0));                                             // R10

endmodule

bind jtag_trace_access jta_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tap_state(tap_state), .tdo(tdo),
  .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr)
);

// File: tb/tb_jtag_trace_access.sv
`timescale 1ns/1ps
module tb_jtag_trace_access;
  import jta_pkg::*;

  logic        clk;
  logic        rst_n;
  logic [3:0]  tap_state;
  logic        tdi;
  logic        tdo;
  logic [6:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_we;
  logic        reg_re;
  logic [31:0] reg_rdata;

  logic [31:0] mem [128];
  int nchk  = 0;
  int nfail = 0;
  int we_cnt = 0;
  int re_cnt = 0;
  logic [6:0]  last_w_addr, last_r_addr;
  logic [31:0] last_w_data;

  jtag_trace_access dut (
    .clk(clk), .rst_n(rst_n), .tap_state(tap_state), .tdi(tdi), .tdo(tdo),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (rst_n) begin
      if (reg_we) begin
        mem[reg_addr] <= reg_wdata;
        we_cnt++;
        last_w_addr = reg_addr;
        last_w_data = reg_wdata;
      end
      if (reg_re) begin
        re_cnt++;
        last_r_addr = reg_addr;
      end
    end
  end

  function automatic logic [31:0] pat(input int a);
    logic [31:0] k;
    k = 32'(a + 1);
    return (k * 32'h9E3779B9) ^ {k[7:0], 24'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  task automatic tick(input tap_st_e s);
    @(negedge clk);
    tap_state = s;
    tdi = 1'b0;
  endtask

  task automatic scan_ir(input logic [3:0] din, output logic [3:0] dout);
    tick(TS_SEL_DR); tick(TS_SEL_IR); tick(TS_CAP_IR);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      tap_state = TS_SHIFT_IR;
      tdi = din[i];
      #1 dout[i] = tdo;
    end
    tick(TS_EXIT1_IR); tick(TS_UPD_IR); tick(TS_IDLE); tick(TS_IDLE);
  endtask

  task automatic scan_dr(input logic [63:0] din, input int len,
                         output logic [63:0] dout);
    dout = '0;
    tick(TS_SEL_DR); tick(TS_CAP_DR);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      tap_state = TS_SHIFT_DR;
      tdi = din[i];
      #1 dout[i] = tdo;
    end
    tick(TS_EXIT1_DR); tick(TS_UPD_DR); tick(TS_IDLE); tick(TS_IDLE);
  endtask

  function automatic logic [63:0] acmd(input bit wr, input int a,
                                       input logic [31:0] d);
    logic [6:0] a7;
    a7 = 7'(a);
    return {24'h0, wr, a7, d};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [3:0]  io;
    logic [63:0] o;
    logic [63:0] c;
    int w0, r0;
    for (int a = 0; a < 128; a++) mem[a] = 32'h5A5A0000 | 32'(a);
    tap_state = TS_IDLE;
    tdi = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1, R10: quiet outputs after reset
    #1;
    chk(tdo == 1'b0 && !reg_we && !reg_re, "R1", {reg_we, reg_re, tdo}, 0);

    // R1, R9: reset instruction is bypass
    scan_dr(64'hB6, 8, o);
    chk(o[7:0] == 8'h6C, "R1", o[7:0], 8'h6C);
    #1 chk(tdo == 1'b0, "R10", tdo, 0);

    // R2: capture pattern of the instruction register
    scan_ir(4'h2, io);
    chk(io == 4'h1, "R2", io, 4'h1);

    // R3: chain-select register
    scan_dr(64'h13, 5, o);
    chk(o[4:0] == 5'h00, "R3", o[4:0], 0);
    scan_dr(64'h13, 5, o);
    chk(o[4:0] == 5'h13, "R3", o[4:0], 5'h13);

    // R4, R11: access instruction with non-zero chain is bypass
    scan_ir(4'hC, io);
    w0 = we_cnt; r0 = re_cnt;
    c = acmd(1'b1, 3, 32'hDEADBEEF);
    scan_dr(c, 40, o);
    chk(o[39:0] == {c[38:0], 1'b0}, "R4", o[39:0], {c[38:0], 1'b0});
    chk(we_cnt == w0 && re_cnt == r0, "R11", we_cnt - w0, 0);

    // select the trace chain
    scan_ir(4'h2, io);
    scan_dr(64'h0, 5, o);
    chk(o[4:0] == 5'h13, "R3", o[4:0], 5'h13);
    scan_ir(4'hC, io);

    // R5, R6: fill every register
    for (int a = 0; a < 128; a++) begin
      w0 = we_cnt; r0 = re_cnt;
      scan_dr(acmd(1'b1, a, pat(a)), 40, o);
      chk(we_cnt == w0 + 1 && re_cnt == r0, "R6", we_cnt - w0, 1);
      chk(last_w_addr == 7'(a) && last_w_data == pat(a), "R5",
          {last_w_addr, last_w_data}, {7'(a), pat(a)});
    end

    // R7, R8, R1: pipelined read of every register
    for (int a = 0; a <= 128; a++) begin
      r0 = re_cnt; w0 = we_cnt;
      scan_dr(acmd(1'b0, (a < 128) ? a : 0, 32'h0), 40, o);
      if (a == 0)
        chk(o[39:0] == 40'h0, "R1", o[39:0], 0);
      else
        chk(o[39:0] == {8'h0, pat(a - 1)}, "R8", o[39:0], {8'h0, pat(a - 1)});
      chk(re_cnt == r0 + 1 && we_cnt == w0 &&
          last_r_addr == 7'((a < 128) ? a : 0), "R7", last_r_addr, a);
    end

    // R8: a write does not disturb the held read word
    scan_dr(acmd(1'b0, 9, 32'h0), 40, o);
    chk(o[31:0] == pat(0), "R8", o[31:0], pat(0));
    scan_dr(acmd(1'b1, 10, 32'h0BADF00D), 40, o);
    chk(o[31:0] == pat(9), "R8", o[31:0], pat(9));
    scan_dr(acmd(1'b0, 10, 32'h0), 40, o);
    chk(o[31:0] == pat(9), "R8", o[31:0], pat(9));
    scan_dr(acmd(1'b0, 0, 32'h0), 40, o);
    chk(o[31:0] == 32'h0BADF00D, "R6", o[31:0], 32'h0BADF00D);

    // R9, R11: sweep every other instruction with chain 0
    for (int ins = 0; ins < 16; ins++) begin
      if (ins != 2 && ins != 12) begin
        scan_ir(4'(ins), io);
        chk(io == 4'h1, "R2", io, 4'h1);
        w0 = we_cnt; r0 = re_cnt;
        c = acmd(1'b1, 1, 32'hC0DE0000 | 32'(ins));
        scan_dr(c, 40, o);
        chk(o[39:0] == {c[38:0], 1'b0}, "R9", o[39:0], {c[38:0], 1'b0});
        chk(we_cnt == w0 && re_cnt == r0, "R11", we_cnt - w0, 0);
      end
    end

    // R2: Test-Logic-Reset restores bypass and clears the chain
    scan_ir(4'h2, io);
    scan_dr(64'h07, 5, o);
    tick(TS_RESET); tick(TS_RESET); tick(TS_IDLE); tick(TS_IDLE);
    scan_dr(64'h5A, 8, o);
    chk(o[7:0] == 8'hB4, "R2", o[7:0], 8'hB4);
    scan_ir(4'h2, io);
    scan_dr(64'h0, 5, o);
    chk(o[4:0] == 5'h00, "R2", o[4:0], 0);
    #1 chk(tdo == 1'b0, "R10", tdo, 0);

    finish_run();
  end

endmodule